// File: doc/BRIEF.md
# ECC Error Capture and Check-Bit Fault Injector

This block sits next to a memory datapath whose 64-bit words are protected by single-error-correct, double-error-detect coding. The read-side decoder reports two kinds of event: correctable and uncorrectable. Each event carries the failing address, an 8-bit syndrome and the 64-bit data word. The block keeps the first event of each kind in its own set of capture registers. It sets a status flag per kind, sets a separate flag when a second event of the same kind arrives before software has cleared the first, and drives a level interrupt until software acknowledges.

On the write side the block can corrupt the generated check byte on purpose. While a force control is set, an 8-bit pattern is XORed into the check byte, so that software can provoke errors and exercise its handlers. All of this is reached through a simple 32-bit register bus. One address window holds the option and capture registers. A second window, at a parameterised base, holds the interrupt status register and a write-one-to-clear acknowledge register.

Top module: `ecc_fault_monitor`

## Requirements
- R1: After reset every readable register reads 0, `irqOut` is 0, and `wrCheckOut` equals `wrCheckIn`.
- R2: The option register at offset 0x00 holds the mode in bits [1:0], force in bit 8 and the XOR pattern in bits [23:16]. All other bits read 0.
- R3: While the mode is 0 or 2, correctable and uncorrectable events change neither the status nor the captured values.
- R4: The first correctable event loads the correctable capture registers and sets status bit 3. These registers are: address at 0x18, syndrome in bits [15:8] of 0x1C, and data low and high words at 0x20 and 0x24.
- R5: The first uncorrectable event loads the uncorrectable capture registers and sets status bit 5. These registers are: address at 0x08, syndrome in bits [15:8] of 0x0C, and data low and high words at 0x10 and 0x14.
- R6: An event of a kind whose first-error bit is still set sets only that kind's second-error bit (bit 4 for correctable, bit 6 for uncorrectable). It leaves that kind's captured values unchanged.
- R7: A correctable and an uncorrectable event in the same cycle are both captured and both flagged.
- R8: Writing to the acknowledge register (interrupt base + 4) clears exactly the status bits that are 1 in the written value. After the first-error bit is cleared, the next event of that kind is captured again.
- R9: `irqOut` is 1 in the cycle after any of status bits 3 to 6 is set, and 0 in the cycle after none is set.
- R10: `wrCheckOut` equals `wrCheckIn` XOR the pattern while force is 1, and equals `wrCheckIn` while force is 0.
- R11: In the cycle in which the option register is written, `wrCheckOut` still uses the option value from before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| regAddr | input | BUS_AW | Register byte address |
| regWrEn | input | 1 | Register write strobe |
| regWrData | input | 32 | Register write data |
| regRdData | output | 32 | Register read data (combinational from regAddr) |
| ceValid | input | 1 | Correctable event strobe |
| ceAddr | input | ERR_AW | Correctable event address |
| ceSyndrome | input | 8 | Correctable event syndrome |
| ceData | input | 64 | Correctable event data word |
| ueValid | input | 1 | Uncorrectable event strobe |
| ueAddr | input | ERR_AW | Uncorrectable event address |
| ueSyndrome | input | 8 | Uncorrectable event syndrome |
| ueData | input | 64 | Uncorrectable event data word |
| wrCheckIn | input | 8 | Generated check byte of write data |
| wrCheckOut | output | 8 | Check byte sent to memory |
| irqOut | output | 1 | Level interrupt |

## Verification
The bench sends repeated events of one kind. A design that reloaded its captures on every event would show the second event's address and data instead of the first. Simultaneous events of both kinds catch a design that prioritises one kind and drops the other. Partial acknowledges catch a design that clears every bit on any write, which would drop the interrupt early. The option is rewritten in the same cycle as write data is checked, which exposes a design that bypasses the new value into the injector a cycle early. Events sent with the mode at 0 and 2 show whether the logging gate decodes the mode correctly.

// File: rtl/ecc_fault_pkg.sv
package ecc_fault_pkg;
  localparam int WORD_W = 64;
  localparam int SYN_W  = 8;

  // strobes from control to datapath
  typedef struct packed {
    logic             ceLoad;
    logic             ueLoad;
    logic             forceInj;
    logic [SYN_W-1:0] pattern;
  } dpStrobe_t;

  // internal status vector order
  localparam int ST_CE  = 0;
  localparam int ST_CE2 = 1;
  localparam int ST_UE  = 2;
  localparam int ST_UE2 = 3;
  localparam int ST_W   = 4;
  localparam int ST_LSB = 3;  // bus bit of ST_CE
endpackage

// File: rtl/ecc_fault_capture.sv
module ecc_fault_capture
  import ecc_fault_pkg::*;
#(
  parameter int ERR_AW = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [ERR_AW-1:0] evAddr,
  input  logic [SYN_W-1:0]  evSyn,
  input  logic [WORD_W-1:0] evData,
  output logic [ERR_AW-1:0] addrQ,
  output logic [SYN_W-1:0]  synQ,
  output logic [WORD_W-1:0] dataQ
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addrQ <= '0;
      synQ  <= '0;
      dataQ <= '0;
    end else if (load) begin
      addrQ <= evAddr;
      synQ  <= evSyn;
      dataQ <= evData;
    end
  end
endmodule

// File: rtl/ecc_fault_dp.sv
module ecc_fault_dp
  import ecc_fault_pkg::*;
#(
  parameter int ERR_AW = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  dpStrobe_t         strb,
  input  logic [ERR_AW-1:0] ceAddr,
  input  logic [SYN_W-1:0]  ceSyndrome,
  input  logic [WORD_W-1:0] ceData,
  input  logic [ERR_AW-1:0] ueAddr,
  input  logic [SYN_W-1:0]  ueSyndrome,
  input  logic [WORD_W-1:0] ueData,
  input  logic [SYN_W-1:0]  wrCheckIn,
  output logic [SYN_W-1:0]  wrCheckOut,
  output logic [ERR_AW-1:0] ceAddrQ,
  output logic [SYN_W-1:0]  ceSynQ,
  output logic [WORD_W-1:0] ceDataQ,
  output logic [ERR_AW-1:0] ueAddrQ,
  output logic [SYN_W-1:0]  ueSynQ,
  output logic [WORD_W-1:0] ueDataQ
);
  localparam int KINDS = 2;

  logic [KINDS-1:0]  loadV;
  logic [ERR_AW-1:0] inAddr [KINDS];
  logic [SYN_W-1:0]  inSyn  [KINDS];
  logic [WORD_W-1:0] inData [KINDS];
  logic [ERR_AW-1:0] qAddr  [KINDS];
  logic [SYN_W-1:0]  qSyn   [KINDS];
  logic [WORD_W-1:0] qData  [KINDS];

  // kind 0 = correctable, kind 1 = uncorrectable
  assign loadV     = {strb.ueLoad, strb.ceLoad};
  assign inAddr[0] = ceAddr;
  assign inSyn[0]  = ceSyndrome;
  assign inData[0] = ceData;
  assign inAddr[1] = ueAddr;
  assign inSyn[1]  = ueSyndrome;
  assign inData[1] = ueData;

  for (genvar k = 0; k < KINDS; k++) begin : g_cap
    ecc_fault_capture #(.ERR_AW(ERR_AW)) u_cap (
      .clk   (clk),
      .rst_n (rst_n),
      .load  (loadV[k]),
      .evAddr(inAddr[k]),
      .evSyn (inSyn[k]),
      .evData(inData[k]),
      .addrQ (qAddr[k]),
      .synQ  (qSyn[k]),
      .dataQ (qData[k])
    );
  end

  assign ceAddrQ = qAddr[0];
  assign ceSynQ  = qSyn[0];
  assign ceDataQ = qData[0];
  assign ueAddrQ = qAddr[1];
  assign ueSynQ  = qSyn[1];
  assign ueDataQ = qData[1];

  // fault injection on the write check byte
  assign wrCheckOut = wrCheckIn ^ (strb.forceInj ? strb.pattern : '0);
endmodule

// File: rtl/ecc_fault_ctrl.sv
module ecc_fault_ctrl
  import ecc_fault_pkg::*;
#(
  parameter int ERR_AW  = 32,
  parameter int BUS_AW  = 8,
  parameter int INT_BASE = 'h40
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [BUS_AW-1:0] regAddr,
  input  logic              regWrEn,
  input  logic [31:0]       regWrData,
  output logic [31:0]       regRdData,
  input  logic              ceValid,
  input  logic              ueValid,
  input  logic [ERR_AW-1:0] ceAddrQ,
  input  logic [SYN_W-1:0]  ceSynQ,
  input  logic [WORD_W-1:0] ceDataQ,
  input  logic [ERR_AW-1:0] ueAddrQ,
  input  logic [SYN_W-1:0]  ueSynQ,
  input  logic [WORD_W-1:0] ueDataQ,
  output dpStrobe_t         strb,
  output logic [ST_W-1:0]   statQ,
  output logic              irqOut
);
  localparam logic [BUS_AW-1:0] A_OPT   = BUS_AW'('h00);
  localparam logic [BUS_AW-1:0] A_UADDR = BUS_AW'('h08);
  localparam logic [BUS_AW-1:0] A_USTAT = BUS_AW'('h0C);
  localparam logic [BUS_AW-1:0] A_ULO   = BUS_AW'('h10);
  localparam logic [BUS_AW-1:0] A_UHI   = BUS_AW'('h14);
  localparam logic [BUS_AW-1:0] A_CADDR = BUS_AW'('h18);
  localparam logic [BUS_AW-1:0] A_CSTAT = BUS_AW'('h1C);
  localparam logic [BUS_AW-1:0] A_CLO   = BUS_AW'('h20);
  localparam logic [BUS_AW-1:0] A_CHI   = BUS_AW'('h24);
  localparam logic [BUS_AW-1:0] A_ISTAT = BUS_AW'(INT_BASE);
  localparam logic [BUS_AW-1:0] A_IACK  = BUS_AW'(INT_BASE + 4);

  logic [1:0]       modeQ;
  logic             forceQ;
  logic [SYN_W-1:0] patQ;
  logic             eccOn;
  logic             ceHit, ueHit;
  logic [ST_W-1:0]  setV, ackV, statD;
  logic             optWr, ackWr;
  logic             unusedWrBits;

  assign optWr = regWrEn && (regAddr == A_OPT);
  assign ackWr = regWrEn && (regAddr == A_IACK);
  assign unusedWrBits = ^{regWrData[31:24], regWrData[15:9], regWrData[7:2]};

  // option register
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      modeQ  <= '0;
      forceQ <= 1'b0;
      patQ   <= '0;
    end else if (optWr) begin
      modeQ  <= regWrData[1:0];
      forceQ <= regWrData[8];
      patQ   <= regWrData[23:16];
    end
  end

  // modes 1 and 3 enable logging, 0 and 2 do not
  assign eccOn = modeQ[0];
  assign ceHit = ceValid && eccOn;
  assign ueHit = ueValid && eccOn;

  always_comb begin
    setV         = '0;
    setV[ST_CE]  = ceHit && !statQ[ST_CE];
    setV[ST_CE2] = ceHit &&  statQ[ST_CE];
    setV[ST_UE]  = ueHit && !statQ[ST_UE];
    setV[ST_UE2] = ueHit &&  statQ[ST_UE];
    ackV  = ackWr ? regWrData[ST_LSB +: ST_W] : '0;
    statD = (statQ & ~ackV) | setV;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      statQ  <= '0;
      irqOut <= 1'b0;
    end else begin
      statQ  <= statD;
      irqOut <= |statQ;
    end
  end

  assign strb.ceLoad   = setV[ST_CE];
  assign strb.ueLoad   = setV[ST_UE];
  assign strb.forceInj = forceQ;
  assign strb.pattern  = patQ;

  always_comb begin
    regRdData = '0;
    unique case (regAddr)
      A_OPT:   regRdData = {8'h0, patQ, 7'h0, forceQ, 6'h0, modeQ};
      A_UADDR: regRdData = 32'(ueAddrQ);
      A_USTAT: regRdData = {16'h0, ueSynQ, 8'h0};
      A_ULO:   regRdData = ueDataQ[31:0];
      A_UHI:   regRdData = ueDataQ[63:32];
      A_CADDR: regRdData = 32'(ceAddrQ);
      A_CSTAT: regRdData = {16'h0, ceSynQ, 8'h0};
      A_CLO:   regRdData = ceDataQ[31:0];
      A_CHI:   regRdData = ceDataQ[63:32];
      A_ISTAT: regRdData = 32'(statQ) << ST_LSB;
      default: regRdData = '0;
    endcase
  end
endmodule

// File: rtl/ecc_fault_monitor.sv
module ecc_fault_monitor
  import ecc_fault_pkg::*;
#(
  parameter int ERR_AW   = 32,
  parameter int BUS_AW   = 8,
  parameter int INT_BASE = 'h40
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [BUS_AW-1:0] regAddr,
  input  logic              regWrEn,
  input  logic [31:0]       regWrData,
  output logic [31:0]       regRdData,
  input  logic              ceValid,
  input  logic [ERR_AW-1:0] ceAddr,
  input  logic [7:0]        ceSyndrome,
  input  logic [63:0]       ceData,
  input  logic              ueValid,
  input  logic [ERR_AW-1:0] ueAddr,
  input  logic [7:0]        ueSyndrome,
  input  logic [63:0]       ueData,
  input  logic [7:0]        wrCheckIn,
  output logic [7:0]        wrCheckOut,
  output logic              irqOut
);
  dpStrobe_t         dpStrb;
  logic [ST_W-1:0]   intStat;
  logic [ERR_AW-1:0] ceAddrQ, ueAddrQ;
  logic [SYN_W-1:0]  ceSynQ, ueSynQ;
  logic [WORD_W-1:0] ceDataQ, ueDataQ;

  ecc_fault_ctrl #(.ERR_AW(ERR_AW), .BUS_AW(BUS_AW), .INT_BASE(INT_BASE)) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .regAddr(regAddr), .regWrEn(regWrEn), .regWrData(regWrData), .regRdData(regRdData),
    .ceValid(ceValid), .ueValid(ueValid),
    .ceAddrQ(ceAddrQ), .ceSynQ(ceSynQ), .ceDataQ(ceDataQ),
    .ueAddrQ(ueAddrQ), .ueSynQ(ueSynQ), .ueDataQ(ueDataQ),
    .strb(dpStrb), .statQ(intStat), .irqOut(irqOut)
  );

  ecc_fault_dp #(.ERR_AW(ERR_AW)) u_dp (
    .clk(clk), .rst_n(rst_n), .strb(dpStrb),
    .ceAddr(ceAddr), .ceSyndrome(ceSyndrome), .ceData(ceData),
    .ueAddr(ueAddr), .ueSyndrome(ueSyndrome), .ueData(ueData),
    .wrCheckIn(wrCheckIn), .wrCheckOut(wrCheckOut),
    .ceAddrQ(ceAddrQ), .ceSynQ(ceSynQ), .ceDataQ(ceDataQ),
    .ueAddrQ(ueAddrQ), .ueSynQ(ueSynQ), .ueDataQ(ueDataQ)
  );
endmodule

// File: rtl/ecc_fault_chk.sv
module ecc_fault_chk
  import ecc_fault_pkg::*;
#(
  parameter int ERR_AW = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ST_W-1:0]   stat,
  input dpStrobe_t         strb,
  input logic              irqOut,
  input logic [7:0]        wrCheckIn,
  input logic [7:0]        wrCheckOut,
  input logic [ERR_AW-1:0] ceAddrQ,
  input logic [ERR_AW-1:0] ueAddrQ,
  input logic [WORD_W-1:0] ceDataQ,
  input logic [WORD_W-1:0] ueDataQ
);
  p_irq_rise_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (|stat) |=> irqOut);
  p_irq_fall_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (stat == '0) |=> !irqOut);
  p_ce_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    stat[ST_CE] |=> ($stable(ceAddrQ) && $stable(ceDataQ)));
  p_ue_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    stat[ST_UE] |=> ($stable(ueAddrQ) && $stable(ueDataQ)));
  p_ce2_after_ce_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stat[ST_CE2]) |-> $past(stat[ST_CE]));
  p_ue2_after_ue_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stat[ST_UE2]) |-> $past(stat[ST_UE]));
  p_no_inject_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !strb.forceInj |-> (wrCheckOut == wrCheckIn));
  p_load_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
    strb.ceLoad |-> !stat[ST_CE]);
endmodule

bind ecc_fault_monitor ecc_fault_chk #(.ERR_AW(ERR_AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .stat(intStat), .strb(dpStrb), .irqOut(irqOut),
  .wrCheckIn(wrCheckIn), .wrCheckOut(wrCheckOut),
  .ceAddrQ(ceAddrQ), .ueAddrQ(ueAddrQ), .ceDataQ(ceDataQ), .ueDataQ(ueDataQ)
);

// File: tb/ecc_fault_monitor_bench.sv
`timescale 1ns/1ps
module ecc_fault_monitor_bench;
  localparam int BUS_AW = 8;
  localparam int IB = 'h40;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [BUS_AW-1:0] regAddr = '0;
  logic              regWrEn = 1'b0;
  logic [31:0]       regWrData = '0;
  logic [31:0]       regRdData;
  logic              ceValid = 1'b0, ueValid = 1'b0;
  logic [31:0]       ceAddr = '0, ueAddr = '0;
  logic [7:0]        ceSyndrome = '0, ueSyndrome = '0;
  logic [63:0]       ceData = '0, ueData = '0;
  logic [7:0]        wrCheckIn = 8'h5A;
  logic [7:0]        wrCheckOut;
  logic              irqOut;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  typedef struct {
    logic [BUS_AW-1:0] addr;
    logic [31:0]       exp;
    string             tag;
  } rdItem_t;
  rdItem_t sbQ[$];
  bit rdPend = 0;

  always #10 clk = ~clk;

  ecc_fault_monitor u_ecc_fault_monitor (
    .clk(clk), .rst_n(rst_n), .regAddr(regAddr), .regWrEn(regWrEn),
    .regWrData(regWrData), .regRdData(regRdData),
    .ceValid(ceValid), .ceAddr(ceAddr), .ceSyndrome(ceSyndrome), .ceData(ceData),
    .ueValid(ueValid), .ueAddr(ueAddr), .ueSyndrome(ueSyndrome), .ueData(ueData),
    .wrCheckIn(wrCheckIn), .wrCheckOut(wrCheckOut), .irqOut(irqOut)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // monitor: pops expected reads and compares at the falling edge
  initial forever begin
    @(negedge clk);
    if (rdPend) begin
      rdItem_t it;
      it = sbQ.pop_front();
      chk($sformatf("%s addr=%h", it.tag, it.addr), regRdData, it.exp);
      rdPend = 0;
    end
  end

  task automatic rdExp(logic [BUS_AW-1:0] a, logic [31:0] e, string tag);
    wait (!rdPend);
    regAddr = a;
    sbQ.push_back('{a, e, tag});
    rdPend = 1;
    wait (!rdPend);
  endtask

  task automatic regWrite(logic [BUS_AW-1:0] a, logic [31:0] d);
    @(posedge clk); #1;
    regAddr = a; regWrData = d; regWrEn = 1'b1;
    @(posedge clk); #1;
    regWrEn = 1'b0;
  endtask

  task automatic pulse(bit doCe, bit doUe, logic [31:0] a, logic [7:0] s, logic [63:0] d);
    @(posedge clk); #1;
    ceValid = doCe; ueValid = doUe;
    ceAddr = a; ceSyndrome = s; ceData = d;
    ueAddr = ~a; ueSyndrome = ~s; ueData = ~d;
    @(posedge clk); #1;
    ceValid = 1'b0; ueValid = 1'b0;
  endtask

  initial begin
    #(20 * 200000);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    // R1 reset state
    chk("R1 irq", 32'(irqOut), 0);
    chk("R1 check passthrough", 32'(wrCheckOut), 32'h5A);
    rdExp(8'h00, 0, "R1 option");
    rdExp(8'h18, 0, "R1 ce addr");
    rdExp(IB, 0, "R1 status");

    // R3 disabled modes 0 and 2
    pulse(1, 1, 32'h1111_0000, 8'h11, 64'h1);
    rdExp(IB, 0, "R3 mode0 status");
    rdExp(8'h18, 0, "R3 mode0 capture");
    regWrite(8'h00, 32'h0000_0002);
    pulse(1, 1, 32'h2222_0000, 8'h22, 64'h2);
    rdExp(IB, 0, "R3 mode2 status");
    rdExp(8'h08, 0, "R3 mode2 capture");
    @(posedge clk); #1 chk("R3 irq", 32'(irqOut), 0);

    // R2 option fields
    regWrite(8'h00, 32'h00AB_0101);
    rdExp(8'h00, 32'h00AB_0101, "R2 option");
    regWrite(8'h00, 32'hFFFF_FFFF);
    rdExp(8'h00, 32'h00FF_0103, "R2 option masked");

    // R10 injection
    chk("R10 force xor", 32'(wrCheckOut), 32'h5A ^ 32'hFF);
    wrCheckIn = 8'h0F; #1;
    chk("R10 force xor 2", 32'(wrCheckOut), 32'h0F ^ 32'hFF);
    wrCheckIn = 8'h5A;
    regWrite(8'h00, 32'h003C_0001);
    chk("R10 force off", 32'(wrCheckOut), 32'h5A);

    // R11 same-cycle option write uses old value
    @(posedge clk); #1;
    regAddr = 8'h00; regWrData = 32'h003C_0101; regWrEn = 1'b1;
    #2 chk("R11 old option in write cycle", 32'(wrCheckOut), 32'h5A);
    @(posedge clk); #1;
    regWrEn = 1'b0;
    chk("R11 new option next cycle", 32'(wrCheckOut), 32'h5A ^ 32'h3C);
    regWrite(8'h00, 32'h0000_0001);

    // R4 first correctable
    pulse(1, 0, 32'h1234_5678, 8'h9D, 64'hDEAD_BEEF_0123_4567);
    chk("R9 irq lag", 32'(irqOut), 0);
    @(posedge clk); #1 chk("R9 irq set", 32'(irqOut), 1);
    rdExp(8'h18, 32'h1234_5678, "R4 ce addr");
    rdExp(8'h1C, 32'h0000_9D00, "R4 ce syndrome");
    rdExp(8'h20, 32'h0123_4567, "R4 ce data lo");
    rdExp(8'h24, 32'hDEAD_BEEF, "R4 ce data hi");
    rdExp(IB, 32'h08, "R4 status");

    // R6 second correctable
    pulse(1, 0, 32'hAAAA_5555, 8'h44, 64'h1);
    rdExp(IB, 32'h18, "R6 status");
    rdExp(8'h18, 32'h1234_5678, "R6 ce addr held");
    rdExp(8'h1C, 32'h0000_9D00, "R6 ce syndrome held");
    rdExp(8'h20, 32'h0123_4567, "R6 ce data held");

    // R8 partial acknowledge
    regWrite(IB + 4, 32'h08);
    rdExp(IB, 32'h10, "R8 partial ack");
    rdExp(IB + 4, 0, "R8 ack reads zero");
    chk("R9 irq held", 32'(irqOut), 1);
    regWrite(IB + 4, 32'h10);
    rdExp(IB, 0, "R8 full ack");
    chk("R9 irq lag on clear", 32'(irqOut), 1);
    @(posedge clk); #1 chk("R9 irq cleared", 32'(irqOut), 0);

    // R8 recapture after ack
    pulse(1, 0, 32'h0BAD_F00D, 8'h3E, 64'h0000_0001_0000_0002);
    rdExp(8'h18, 32'h0BAD_F00D, "R8 recapture addr");
    rdExp(8'h24, 32'h0000_0001, "R8 recapture data hi");
    regWrite(IB + 4, 32'h78);
    rdExp(IB, 0, "R8 ack all");

    // R7 simultaneous events, R5 uncorrectable capture
    pulse(1, 1, 32'h0000_1000, 8'h81, 64'h0011_2233_4455_6677);
    rdExp(IB, 32'h28, "R7 both flagged");
    rdExp(8'h18, 32'h0000_1000, "R7 ce addr");
    rdExp(8'h08, 32'hFFFF_EFFF, "R5 ue addr");
    rdExp(8'h0C, 32'h0000_7E00, "R5 ue syndrome");
    rdExp(8'h10, 32'hBBAA_9988, "R5 ue data lo");
    rdExp(8'h14, 32'hFFEE_DDCC, "R5 ue data hi");

    // R6 second uncorrectable
    pulse(0, 1, 32'h0000_2000, 8'h01, 64'h5);
    rdExp(IB, 32'h68, "R6 ue second");
    rdExp(8'h08, 32'hFFFF_EFFF, "R6 ue addr held");
    rdExp(8'h14, 32'hFFEE_DDCC, "R6 ue data held");

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule